// File: doc/BRIEF.md
# Sampled Reset Qualifier

This block turns an asynchronous, active-high reset pin into the internal reset of a small microcontroller core. The core's machine cycle is twelve oscillator clocks. The block contains the machine-cycle sequencer, which splits each cycle into six states of two phases each. The pin goes through a two-flop synchroniser. The synchronised level is looked at only once per machine cycle, on the clock that ends state 5, phase 2.

The internal reset turns on only when the pin has been seen high at two sample slots in a row, which spans two machine cycles or 24 oscillator clocks. The first low sample drops the request. The core then leaves reset at the start of the following machine cycle. While `core_rst_o` is high the core loads its program counter with 0x0000 and clears its state. The qualification is the same at power-on and when the button is pressed while the core runs.

The state counter and the sampling flops start from a separate active-low cold reset, `rst_ni`. In the core this comes from the supply-good logic. The analog RC network and the Schmitt input stage sit outside this block.

Top module: `rst_qualifier`

## Requirements
- R1: While `rst_ni` is low, `core_rst_o` is 1, `state_o` is 1 and `phase_o` is 0.
- R2: The sequencer repeats every 12 clocks. `state_o` steps through 1 to 6 and holds each value for two clocks. `phase_o` is 0 (phase 1) on the first of those clocks and 1 (phase 2) on the second.
- R3: The pin is sampled only on the clock edge that ends state 5, phase 2. The sample is the synchronised level from two clocks earlier. A high level that misses every slot has no effect on `core_rst_o`.
- R4: `core_rst_o` rises on the edge that takes the second consecutive high sample. It is therefore first seen high while `state_o` is 6 and `phase_o` is 0.
- R5: A single high sample with a low sample on each side leaves `core_rst_o` at 0.
- R6: After a low sample, `core_rst_o` stays high for the rest of that machine cycle. It falls on the edge that starts the next cycle, so it is first seen low with `state_o` 1 and `phase_o` 0.
- R7: While the pin stays high, reset is entered after two machine cycles and held. This happens the same way at any point of a run.
- R8: After `rst_ni` is released, `core_rst_o` stays high through the first machine cycle. It clears at the next cycle start unless the pin was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Cold reset of sequencer and sampling flops, active low, asynchronous |
| rst_pin_i | input | 1 | External reset pin, active high, asynchronous |
| core_rst_o | output | 1 | Internal core reset: program counter to 0x0000, core state cleared |
| state_o | output | 3 | Current state, 1 to 6 |
| phase_o | output | 1 | Current phase: 0 = phase 1, 1 = phase 2 |

## Verification
A faulty state counter shows up within one machine cycle. It would make the state and phase outputs step, wrap or pair wrongly. It would also move the rise of the internal reset off the state 6, phase 1 clock and its fall off the cycle start. A wrong sample-history count shows up at the end of the second or third machine cycle of a pin pattern. It would either enter reset after a single high sample or fail to enter after two. Pulses placed just before the slot or well away from it expose a sampling point that is off by a few clocks, or a synchroniser with the wrong depth.

// File: rtl/rst_qualifier.sv
module rst_qualifier #(
  parameter int CYC_LEN     = 12,
  parameter int SLOT        = 9,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD        = 2
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               rst_pin_i,
  output logic                               core_rst_o,
  output logic [$clog2(CYC_LEN/2+1)-1:0]     state_o,
  output logic                               phase_o
);
  localparam int CW = $clog2(CYC_LEN);
  localparam int SW = $clog2(CYC_LEN/2+1);
  localparam int HW = $clog2(HOLD+1);

  logic [CW-1:0]          cnt_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [HW-1:0]          hits_q;
  logic                   rst_q;

  wire slot  = (cnt_q == CW'(SLOT));
  wire wrap  = (cnt_q == CW'(CYC_LEN-1));
  wire pin_s = sync_q[SYNC_STAGES-1];
  wire armed = (hits_q >= HW'(HOLD-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= wrap ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rst_pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           hits_q <= '0;
    else if (slot) begin
      if (!pin_s)          hits_q <= '0;
      else if (hits_q != HW'(HOLD)) hits_q <= hits_q + HW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         rst_q <= 1'b1;
    else if (slot && pin_s && armed)     rst_q <= 1'b1;
    else if (wrap && hits_q == '0)       rst_q <= 1'b0;
  end

  assign core_rst_o = rst_q;
  assign state_o    = SW'(cnt_q >> 1) + SW'(1);
  assign phase_o    = cnt_q[0];
endmodule

// File: rtl/rst_qualifier_chk.sv
module rst_qualifier_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       core_rst_o,
  input logic [2:0] state_o,
  input logic       phase_o
);
  AST_STATE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o >= 3'd1 && state_o <= 3'd6); // R2
  AST_CYCLE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd6 && phase_o) |=> (state_o == 3'd1 && !phase_o)); // R2
  AST_PHASE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_o |=> (phase_o && $stable(state_o))); // R2
  AST_RISE_AFTER_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_o) |-> (state_o == 3'd6 && !phase_o)); // R4
  AST_FALL_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> (state_o == 3'd1 && !phase_o)); // R6
endmodule

bind rst_qualifier rst_qualifier_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .core_rst_o(core_rst_o),
  .state_o(state_o), .phase_o(phase_o)
);

// File: tb/rst_qualifier_tb.sv
module rst_qualifier_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rst_pin_i = 1'b0;
  logic core_rst_o;
  logic [2:0] state_o;
  logic phase_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  rst_qualifier u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_pin_i(rst_pin_i),
    .core_rst_o(core_rst_o), .state_o(state_o), .phase_o(phase_o)
  );

  // {pin level held for a whole machine cycle, expected core_rst_o at next cycle start}
  localparam logic [1:0] VEC [13] = '{
    2'b00, 2'b10, 2'b00, 2'b10, 2'b11, 2'b11, 2'b00,
    2'b10, 2'b11, 2'b00, 2'b00, 2'b10, 2'b00
  };

  function automatic int cur_cnt();
    return (int'(state_o) - 1) * 2 + int'(phase_o);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_cnt(int k);
    do @(negedge clk_i); while (cur_cnt() != k);
  endtask

  initial begin
    #200_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 core_rst_o", int'(core_rst_o), 1);
    chk("R1 state_o", int'(state_o), 1);
    chk("R1 phase_o", int'(phase_o), 0);
    rst_ni = 1'b1;
    for (int i = 0; i < 12; i++) begin
      chk("R2 state_o", int'(state_o), i / 2 + 1);
      chk("R2 phase_o", int'(phase_o), i % 2);
      if (i == 11) chk("R8 held first cycle", int'(core_rst_o), 1);
      @(negedge clk_i);
    end
    chk("R8 cleared at cycle start", int'(core_rst_o), 0);

    for (int v = 0; v < 13; v++) begin
      rst_pin_i = VEC[v][1];
      wait_cnt(0);
      chk(VEC[v][0] ? "R7 vector" : (VEC[v][1] ? "R5 vector" : "R6 vector"),
          int'(core_rst_o), int'(VEC[v][0]));
    end

    // R3: highs away from the slot, two cycles running
    for (int c = 0; c < 2; c++) begin
      rst_pin_i = 1'b1;
      wait_cnt(5);
      rst_pin_i = 1'b0;
      wait_cnt(0);
    end
    chk("R3 off-slot pulses", int'(core_rst_o), 0);

    // R3/R4: short pulses that just cover the slot
    wait_cnt(7); rst_pin_i = 1'b1;
    wait_cnt(9); rst_pin_i = 1'b0;
    chk("R3 one slot hit", int'(core_rst_o), 0);
    wait_cnt(7); rst_pin_i = 1'b1;
    wait_cnt(9); rst_pin_i = 1'b0;
    chk("R4 before slot edge", int'(core_rst_o), 0);
    wait_cnt(10);
    chk("R4 right after slot", int'(core_rst_o), 1);
    wait_cnt(11);
    chk("R4 held", int'(core_rst_o), 1);
    wait_cnt(10);
    chk("R6 after low sample", int'(core_rst_o), 1);
    wait_cnt(11);
    chk("R6 end of cycle", int'(core_rst_o), 1);
    wait_cnt(0);
    chk("R6 released at start", int'(core_rst_o), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule